// File: doc/BRIEF.md
# Dual-Clock FIFO with Paired Enables

This block is a first-in first-out buffer for 9-bit words that crosses between two unrelated clocks. The producer writes on its own clock and the consumer reads on another. A write happens only when both write-enable inputs are high on the same write-clock edge. A read happens only when both read-enable inputs are high on the same read-clock edge. Either input of a pair can therefore stall its side by itself.

Each side has one flag, computed in its own clock domain. The write side sees a full flag and the read side sees an empty flag. A read word is loaded into an output register, and that register drives the data bus only while the active-low output enable is low. When the output enable is high, the bus is released to high impedance.

Both pointers are held in Gray code. Each is passed to the opposite domain through a two-stage synchronizer. This gives the flags a fixed crossing latency: the first word written into an empty buffer becomes visible between one and two read-clock periods after its write edge. A single asynchronous reset returns the buffer to empty.

Top module: `dcfifo_gated`

## Requirements
- R1: Words leave the buffer in the order they were written, and each keeps all 9 bits unchanged.
- R2: A word is stored on a write-clock rising edge only if wrEnA and wrEnB are both 1 and fullFlag is 0. With only one of the two write enables at 1, nothing is stored.
- R3: A word is read on a read-clock rising edge only if rdEnA and rdEnB are both 1 and emptyFlag is 0. The word is loaded into the output register at that edge. With only one of the two read enables at 1, the output register and the read position stay unchanged.
- R4: fullFlag is 1 while the write side sees DEPTH stored words, and a write attempted while it is 1 stores nothing. After a read frees a location, fullFlag returns to 0 within three write-clock edges.
- R5: After a write into an empty buffer, emptyFlag falls at the second read-clock rising edge after the write edge. This places the release more than one and at most two read-clock periods after the write.
- R6: With outEnN at 0, dataOut shows the output register. With outEnN at 1, dataOut is not driven (high impedance).
- R7: A read attempted while emptyFlag is 1 leaves the output register and the read position unchanged.
- R8: Each pointer crossing between the clock domains is Gray coded, and at most one of its bits changes per clock edge.
- R9: While rstN is 0, emptyFlag is 1, fullFlag is 0 and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low, for both domains |
| wrEnA | input | 1 | First write enable, active high |
| wrEnB | input | 1 | Second write enable, active high |
| dataIn | input | 9 | Word to be written |
| fullFlag | output | 1 | Buffer full, in the write-clock domain |
| rdEnA | input | 1 | First read enable, active high |
| rdEnB | input | 1 | Second read enable, active high |
| outEnN | input | 1 | Output enable for dataOut, active low |
| emptyFlag | output | 1 | Buffer empty, in the read-clock domain |
| dataOut | output | 9 | Output register contents, high impedance while outEnN is 1 |

## Verification
The bench builds the block with DEPTH set to 8. This lets the full boundary be reached within a few writes. It also brings the rejected write while full, and the full release after one read, within a short test. The write clock runs at 4 ns and the read clock at 7 ns with a quarter-nanosecond offset, so no write and read edges ever coincide. Over repeated trials, the write edge lands at different phases of the read clock, which exercises the one-to-two-period empty release.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Strobes from the control block to the datapath, one per clock domain.
  typedef struct packed {
    logic wrCommit;  // write-clock domain: store dataIn this edge
    logic rdCommit;  // read-clock domain: load output register this edge
  } fifoStrobe_t;

endpackage

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnA,
  input  logic              wrEnB,
  input  logic              rdEnA,
  input  logic              rdEnB,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullFlag,
  output logic              emptyFlag,
  output logic [PTR_W-1:0]  wrPtrGray,
  output logic [PTR_W-1:0]  rdPtrGray
);

  // ---------------- write-clock domain ----------------
  logic [PTR_W-1:0] wrBin, wrBinNext, rdGraySyncW, fullPattern;
  logic             wrGo;

  gray_sync #(.WIDTH(PTR_W), .STAGES(2)) rdToWr_i (
    .clk    (wrClk),
    .rstN   (rstN),
    .asyncIn(rdPtrGray),
    .syncOut(rdGraySyncW)
  );

  // Full when the write pointer is one lap ahead of the synchronized read pointer.
  assign fullPattern = {~rdGraySyncW[PTR_W-1 -: 2], rdGraySyncW[PTR_W-3:0]};
  assign fullFlag    = (wrPtrGray == fullPattern);
  assign wrGo        = wrEnA & wrEnB & ~fullFlag;
  assign wrBinNext   = wrBin + PTR_W'(wrGo);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin     <= '0;
      wrPtrGray <= '0;
    end else begin
      wrBin     <= wrBinNext;
      wrPtrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  // ---------------- read-clock domain ----------------
  logic [PTR_W-1:0] rdBin, rdBinNext, wrGraySyncR;
  logic             rdGo;

  gray_sync #(.WIDTH(PTR_W), .STAGES(2)) wrToRd_i (
    .clk    (rdClk),
    .rstN   (rstN),
    .asyncIn(wrPtrGray),
    .syncOut(wrGraySyncR)
  );

  assign emptyFlag = (rdPtrGray == wrGraySyncR);
  assign rdGo      = rdEnA & rdEnB & ~emptyFlag;
  assign rdBinNext = rdBin + PTR_W'(rdGo);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin     <= '0;
      rdPtrGray <= '0;
    end else begin
      rdBin     <= rdBinNext;
      rdPtrGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  assign strobe.wrCommit = wrGo;
  assign strobe.rdCommit = rdGo;
  assign wrAddr          = wrBin[ADDR_W-1:0];
  assign rdAddr          = rdBin[ADDR_W-1:0];

endmodule

// File: rtl/fifo_data.sv
module fifo_data
  import dcfifo_pkg::*;
#(
  parameter int W      = 9,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [W-1:0]      dataIn,
  output logic [W-1:0]      dataQ
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrCommit) store[wrAddr] <= dataIn;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                dataQ <= '0;
    else if (strobe.rdCommit) dataQ <= store[rdAddr];
  end

endmodule

// File: rtl/dcfifo_gated.sv
module dcfifo_gated
  import dcfifo_pkg::*;
#(
  parameter int W      = 9,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic         wrClk,
  input  logic         rdClk,
  input  logic         rstN,
  input  logic         wrEnA,
  input  logic         wrEnB,
  input  logic [W-1:0] dataIn,
  output logic         fullFlag,
  input  logic         rdEnA,
  input  logic         rdEnB,
  input  logic         outEnN,
  output logic         emptyFlag,
  output logic [W-1:0] dataOut
);

  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [PTR_W-1:0]  wrPtrGray, rdPtrGray;
  logic [W-1:0]      dataQ;

  fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .wrEnA    (wrEnA),
    .wrEnB    (wrEnB),
    .rdEnA    (rdEnA),
    .rdEnB    (rdEnB),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .fullFlag (fullFlag),
    .emptyFlag(emptyFlag),
    .wrPtrGray(wrPtrGray),
    .rdPtrGray(rdPtrGray)
  );

  fifo_data #(.W(W), .DEPTH(DEPTH)) data_i (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .dataIn(dataIn),
    .dataQ (dataQ)
  );

  assign dataOut = outEnN ? {W{1'bz}} : dataQ;

endmodule

// File: rtl/dcfifo_gated_chk.sv
module dcfifo_gated_chk #(
  parameter int W     = 9,
  parameter int PTR_W = 9
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rstN,
  input logic             wrEnA,
  input logic             wrEnB,
  input logic             rdEnA,
  input logic             rdEnB,
  input logic             fullFlag,
  input logic             emptyFlag,
  input logic [PTR_W-1:0] wrPtrGray,
  input logic [PTR_W-1:0] rdPtrGray,
  input logic [W-1:0]     dataQ
);

  AST_WR_NEEDS_BOTH: assert property (@(posedge wrClk) disable iff (!rstN)
    !(wrEnA && wrEnB) |=> $stable(wrPtrGray)); // R2

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |=> $stable(wrPtrGray)); // R4

  AST_RD_NEEDS_BOTH: assert property (@(posedge rdClk) disable iff (!rstN)
    !(rdEnA && rdEnB) |=> ($stable(rdPtrGray) && $stable(dataQ))); // R3

  AST_EMPTY_HOLDS_OUTPUT: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |=> ($stable(rdPtrGray) && $stable(dataQ))); // R7

  AST_WR_GRAY_STEP: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrPtrGray ^ $past(wrPtrGray)) <= 1); // R8

  AST_RD_GRAY_STEP: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdPtrGray ^ $past(rdPtrGray)) <= 1); // R8

endmodule

bind dcfifo_gated dcfifo_gated_chk #(.W(W), .PTR_W(PTR_W)) chk_i (
  .wrClk    (wrClk),
  .rdClk    (rdClk),
  .rstN     (rstN),
  .wrEnA    (wrEnA),
  .wrEnB    (wrEnB),
  .rdEnA    (rdEnA),
  .rdEnB    (rdEnB),
  .fullFlag (fullFlag),
  .emptyFlag(emptyFlag),
  .wrPtrGray(wrPtrGray),
  .rdPtrGray(rdPtrGray),
  .dataQ    (dataQ)
);

// File: tb/dcfifo_gated_tb_top.sv
`timescale 1ns/10ps
module dcfifo_gated_tb_top;

  localparam int W     = 9;
  localparam int DEPTH = 8;

  logic         wrClk, rdClk, rstN;
  logic         wrEnA, wrEnB, rdEnA, rdEnB, outEnN;
  logic [W-1:0] dataIn;
  logic         fullFlag, emptyFlag;
  wire  [W-1:0] dataOut;

  generate
    for (genvar b = 0; b < W; b++) begin : g_pull
      pullup (dataOut[b]);
    end
  endgenerate

  dcfifo_gated #(.W(W), .DEPTH(DEPTH)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnA(wrEnA), .wrEnB(wrEnB), .dataIn(dataIn), .fullFlag(fullFlag),
    .rdEnA(rdEnA), .rdEnB(rdEnB), .outEnN(outEnN),
    .emptyFlag(emptyFlag), .dataOut(dataOut)
  );

  // 250 MHz write clock; 7 ns read clock offset so edges never coincide.
  initial begin
    wrClk = 0;
    forever #2 wrClk = ~wrClk;
  end
  initial begin
    rdClk = 0;
    #0.25;
    forever #3.5 rdClk = ~rdClk;
  end

  int total = 0;
  int bad   = 0;
  logic [W-1:0] refQ [$];
  bit  wrDone;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $realtime);
    end
  endtask

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic pushWord(input logic [W-1:0] val);
    bit go;
    @(negedge wrClk);
    dataIn = val; wrEnA = 1; wrEnB = 1;
    go = !fullFlag;
    @(posedge wrClk);
    if (go) refQ.push_back(val);
    @(negedge wrClk);
    wrEnA = 0; wrEnB = 0;
  endtask

  task automatic popWord();
    bit go;
    logic [W-1:0] exp;
    @(negedge rdClk);
    rdEnA = 1; rdEnB = 1;
    go = !emptyFlag;
    @(posedge rdClk);
    @(negedge rdClk);
    rdEnA = 0; rdEnB = 0;
    if (go) begin
      if (refQ.size() == 0) check(0, "R3 read while model empty", 1, 0);
      else begin
        exp = refQ.pop_front();
        check(dataOut == exp, "R1 read order", int'(dataOut), int'(exp));
      end
    end
  endtask

  task automatic drain();
    repeat (4) @(negedge rdClk);
    while (refQ.size() != 0) popWord();
    repeat (4) @(negedge rdClk);
  endtask

  initial begin
    real t0, lat;
    logic [W-1:0] held;
    int n;
    wrEnA = 0; wrEnB = 0; rdEnA = 0; rdEnB = 0; outEnN = 0; dataIn = '0;
    wrDone = 0;
    rstN = 1;
    #0.1 rstN = 0;
    #30;
    // R9 reset state
    check(emptyFlag == 1, "R9 empty in reset", emptyFlag, 1);
    check(fullFlag == 0, "R9 full in reset", fullFlag, 0);
    check(dataOut == 0, "R9 output register in reset", int'(dataOut), 0);
    @(negedge wrClk) rstN = 1;
    repeat (3) @(negedge rdClk);

    // R2: one write enable alone stores nothing
    @(negedge wrClk); dataIn = 9'h1C3; wrEnA = 1; wrEnB = 0;
    repeat (4) @(negedge wrClk);
    wrEnA = 0; wrEnB = 1;
    repeat (4) @(negedge wrClk);
    wrEnB = 0;
    repeat (5) @(negedge rdClk);
    check(emptyFlag == 1, "R2 single write enable stored a word", emptyFlag, 1);

    // R5: empty release latency, several phases
    for (int k = 0; k < 4; k++) begin
      repeat (k + 1) @(negedge wrClk);
      check(emptyFlag == 1, "R5 precondition empty", emptyFlag, 1);
      dataIn = 9'h020 + 9'(k); wrEnA = 1; wrEnB = 1;
      @(posedge wrClk);
      t0 = $realtime;
      refQ.push_back(9'h020 + 9'(k));
      @(negedge wrClk);
      wrEnA = 0; wrEnB = 0;
      wait (emptyFlag == 0);
      lat = $realtime - t0;
      check(lat > 7.0 && lat <= 14.0, "R5 empty release latency (ns)", int'(lat), 14);
      drain();
    end

    // R3: single read enable does not read
    pushWord(9'h0F0);
    repeat (4) @(negedge rdClk);
    held = dataOut;
    rdEnA = 1; rdEnB = 0;
    repeat (3) @(negedge rdClk);
    rdEnA = 0; rdEnB = 1;
    repeat (3) @(negedge rdClk);
    rdEnB = 0;
    check(dataOut == held, "R3 output changed on single read enable", int'(dataOut), int'(held));
    check(emptyFlag == 0, "R3 word lost on single read enable", emptyFlag, 0);
    popWord();
    check(dataOut == 9'h0F0, "R3 word loaded after read edge", int'(dataOut), 9'h0F0);

    // R4: fill to full, rejected write, release after a read
    drain();
    for (int i = 0; i < DEPTH; i++) pushWord(9'h100 + 9'(i));
    repeat (4) @(negedge wrClk);
    check(fullFlag == 1, "R4 full after DEPTH writes", fullFlag, 1);
    pushWord(9'h1AA);
    check(fullFlag == 1, "R4 full after rejected write", fullFlag, 1);
    check(refQ.size() == DEPTH, "R4 write accepted while full", refQ.size(), DEPTH);
    popWord();
    n = 0;
    while (fullFlag && n < 8) begin
      @(negedge wrClk);
      n++;
    end
    check(n <= 3, "R4 full release edges", n, 3);
    drain();
    check(emptyFlag == 1, "R4 extra word present after drain", emptyFlag, 1);

    // R7: read while empty holds output
    held = dataOut;
    popWord();
    repeat (2) @(negedge rdClk);
    check(dataOut == held, "R7 output changed on empty read", int'(dataOut), int'(held));

    // R6: output enable
    pushWord(9'h055);
    repeat (5) @(negedge rdClk);
    popWord();
    outEnN = 1;
    #1;
    check(dataOut == 9'h1FF, "R6 bus driven with outEnN high", int'(dataOut), 9'h1FF);
    outEnN = 0;
    #1;
    check(dataOut == 9'h055, "R6 bus with outEnN low", int'(dataOut), 9'h055);

    // R1/R2/R3: streaming with random enables, compared every clock
    fork
      begin
        bit go;
        for (int i = 0; i < 300; i++) begin
          @(negedge wrClk);
          if (refQ.size() == DEPTH)
            check(fullFlag == 1, "R4 full flag with DEPTH words", fullFlag, 1);
          wrEnA = ($urandom_range(0, 3) != 0);
          wrEnB = ($urandom_range(0, 3) != 0);
          dataIn = 9'($urandom);
          go = wrEnA && wrEnB && !fullFlag;
          @(posedge wrClk);
          if (go) refQ.push_back(dataIn);
        end
        @(negedge wrClk);
        wrEnA = 0; wrEnB = 0;
        wrDone = 1;
      end
      begin
        bit go, pend;
        logic [W-1:0] exp;
        pend = 0;
        while (!(wrDone && refQ.size() == 0)) begin
          @(negedge rdClk);
          if (pend) begin
            check(dataOut == exp, "R1 stream order", int'(dataOut), int'(exp));
            pend = 0;
          end
          if (refQ.size() == 0)
            check(emptyFlag == 1, "R5 empty flag with no words", emptyFlag, 1);
          rdEnA = ($urandom_range(0, 2) != 0);
          rdEnB = ($urandom_range(0, 2) != 0);
          go = rdEnA && rdEnB && !emptyFlag;
          @(posedge rdClk);
          if (go) begin
            if (refQ.size() == 0) check(0, "R3 stream read while model empty", 1, 0);
            else begin
              exp = refQ.pop_front();
              pend = 1;
            end
          end
        end
        @(negedge rdClk);
        rdEnA = 0; rdEnB = 0;
        if (pend) check(dataOut == exp, "R1 stream order", int'(dataOut), int'(exp));
      end
    join

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule